// File: doc/BRIEF.md
# Carry-Skip Block Adder

A purely combinational binary adder that sums two `WIDTH`-bit operands and a carry-in. It produces a `WIDTH`-bit sum and a carry-out. The operand bits are cut into equal groups of `GRP` bits.

Inside a group the carry ripples from bit to bit. Each bit derives three flags from its two operand bits: generate (both ones), propagate (exactly one is one) and kill (both zeros). The carry leaving a bit is its generate OR its propagate AND the carry arriving at it. Each sum bit is the propagate flag XOR the arriving carry. When every bit of a group propagates, a skip multiplexer hands the group's incoming carry straight to its outgoing carry and bypasses the group's internal chain. The slowest path therefore ripples through the lowest group, skips the middle groups and ripples through the highest group.

The block has no clock, no reset and no state. The project's stateful naming and layout conventions are kept, but there is no state machine to describe. It is used anywhere a wide add needs a shorter carry path than a plain ripple chain, at little extra logic.

Top module: `csk_adder`

## Requirements
- R1: `sum_o` equals the low `WIDTH` bits of `a_i + b_i + cin_i` for every operand pair and carry-in.
- R2: `cout_o` equals bit `WIDTH` of the full-precision value `a_i + b_i + cin_i`.
- R3: With both operands zero, `sum_o` equals `cin_i` zero-extended and `cout_o` is 0, because every bit kills.
- R4: With `b_i` equal to the bitwise inverse of `a_i`, every bit propagates. `cin_i = 0` then gives an all-ones sum and `cout_o = 0`, and `cin_i = 1` gives a zero sum and `cout_o = 1`.
- R5: For any group whose bits all propagate, the carry leaving the group equals the carry entering it.
- R6: A group that contains a non-propagating bit produces the carry-out of its own slice sum, which is operand slice plus operand slice plus group carry-in, taken at bit `GRP`.
- R7: A carry generated in bit 0 that travels through every higher bit by propagation reaches `cout_o`. For example, `a_i = 1` and `b_i` all ones give a zero sum with `cout_o = 1`.
- R8: No bit position has its generate and kill flags both true.
- R9: A configuration in which `WIDTH` is not a whole multiple of `GRP` is rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | WIDTH | Sum bits |
| cout_o | output | 1 | Carry out of the top bit |

## Verification
The bound checker evaluates the following whenever the inputs change:
- the full result against the arithmetic sum;
- the carry of every group against the arithmetic carry of its slice;
- that a fully propagating group passes its carry-in straight through;
- that generate and kill never coincide in any bit.

Only the bench's scenarios show that the chosen operand patterns really reach each path. These patterns are:
- every bit killing;
- every bit propagating, with both carry-in values;
- a generated carry skipping a propagating group;
- a carry absorbed by a generating top bit;
- the full-width worst-case path.

The bench also covers every input combination of a narrow second instance. The elaboration rejection of a non-dividing group size cannot be shown by a passing run.

// File: rtl/csk_pkg.sv
package csk_pkg;

    // Per-bit carry flags derived from one operand bit pair
    typedef struct packed {
        logic gen;
        logic prop;
        logic kill;
    } bit_flags_t;

endpackage

// File: rtl/csk_bit_cell.sv
module csk_bit_cell
    import csk_pkg::*;
(
    input  logic       a_i,
    input  logic       b_i,
    input  logic       c_i,
    output bit_flags_t flags_o,
    output logic       s_o,
    output logic       c_o
);

    always_comb begin
        flags_o.gen  = a_i & b_i;
        flags_o.prop = a_i ^ b_i;
        flags_o.kill = ~a_i & ~b_i;
        c_o          = flags_o.gen | (flags_o.prop & c_i);
        s_o          = flags_o.prop ^ c_i;
    end

endmodule

// File: rtl/csk_group.sv
module csk_group
    import csk_pkg::*;
#(
    parameter int GRP = 4
) (
    input  logic [GRP-1:0] a_i,
    input  logic [GRP-1:0] b_i,
    input  logic           cin_i,
    output logic [GRP-1:0] sum_o,
    output logic           cout_o,
    output logic           gprop_o,
    output logic [GRP-1:0] gen_o,
    output logic [GRP-1:0] kill_o
);

    logic [GRP:0]   rip_c;
    logic [GRP-1:0] prop_v;
    bit_flags_t     flags [GRP];

    assign rip_c[0] = cin_i;

    for (genvar i = 0; i < GRP; i++) begin : g_bit
        csk_bit_cell u_cell (
            .a_i     (a_i[i]),
            .b_i     (b_i[i]),
            .c_i     (rip_c[i]),
            .flags_o (flags[i]),
            .s_o     (sum_o[i]),
            .c_o     (rip_c[i+1])
        );
        assign prop_v[i] = flags[i].prop;
        assign gen_o[i]  = flags[i].gen;
        assign kill_o[i] = flags[i].kill;
    end

    // Group-wide propagate steers the bypass multiplexer
    assign gprop_o = &prop_v;
    assign cout_o  = gprop_o ? cin_i : rip_c[GRP];

endmodule

// File: rtl/csk_adder.sv
module csk_adder #(
    parameter int WIDTH = 32,
    parameter int GRP   = 4
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o
);

    localparam int NGRP = WIDTH / GRP;

    // R9: the group size must tile the operand width exactly
    if ((GRP < 1) || (WIDTH % GRP != 0)) begin : g_bad_cfg
        $error("csk_adder: WIDTH must be a whole multiple of GRP");
    end

    logic [NGRP:0]    grp_c;
    logic [NGRP-1:0]  grp_prop;
    logic [WIDTH-1:0] gen_v;
    logic [WIDTH-1:0] kill_v;

    assign grp_c[0] = cin_i;

    for (genvar j = 0; j < NGRP; j++) begin : g_grp
        csk_group #(.GRP(GRP)) u_grp (
            .a_i     (a_i[j*GRP +: GRP]),
            .b_i     (b_i[j*GRP +: GRP]),
            .cin_i   (grp_c[j]),
            .sum_o   (sum_o[j*GRP +: GRP]),
            .cout_o  (grp_c[j+1]),
            .gprop_o (grp_prop[j]),
            .gen_o   (gen_v[j*GRP +: GRP]),
            .kill_o  (kill_v[j*GRP +: GRP])
        );
    end

    assign cout_o = grp_c[NGRP];

endmodule

// File: rtl/csk_adder_chk.sv
module csk_adder_chk #(
    parameter int WIDTH = 32,
    parameter int GRP   = 4
) (
    input logic [WIDTH-1:0]      a_i,
    input logic [WIDTH-1:0]      b_i,
    input logic                  cin_i,
    input logic [WIDTH-1:0]      sum_o,
    input logic                  cout_o,
    input logic [WIDTH/GRP:0]    grp_c,
    input logic [WIDTH/GRP-1:0]  grp_prop,
    input logic [WIDTH-1:0]      gen_v,
    input logic [WIDTH-1:0]      kill_v
);

    localparam int NGRP = WIDTH / GRP;

    logic [WIDTH:0] ref_total;
    assign ref_total = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};

    always_comb begin
        // R1
        sum_matches_chk: assert (sum_o == ref_total[WIDTH-1:0]);
        // R2
        carry_out_chk: assert (cout_o == ref_total[WIDTH]);
        // R8
        gen_kill_excl_chk: assert ((gen_v & kill_v) == '0);
    end

    for (genvar j = 0; j < NGRP; j++) begin : g_gchk
        logic [GRP:0] slice_total;
        assign slice_total = {1'b0, a_i[j*GRP +: GRP]} + {1'b0, b_i[j*GRP +: GRP]}
                           + {{GRP{1'b0}}, grp_c[j]};
        always_comb begin
            // R5
            if (grp_prop[j]) begin
                group_skip_chk: assert (grp_c[j+1] == grp_c[j]);
            end
            // R6
            group_carry_chk: assert (grp_c[j+1] == slice_total[GRP]);
        end
    end

endmodule

bind csk_adder csk_adder_chk #(.WIDTH(WIDTH), .GRP(GRP)) u_chk (
    .a_i      (a_i),
    .b_i      (b_i),
    .cin_i    (cin_i),
    .sum_o    (sum_o),
    .cout_o   (cout_o),
    .grp_c    (grp_c),
    .grp_prop (grp_prop),
    .gen_v    (gen_v),
    .kill_v   (kill_v)
);

// File: tb/csk_adder_bench.sv
module csk_adder_bench;

    localparam int W  = 32;
    localparam int G  = 4;
    localparam int SW = 6;
    localparam int SG = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic [W-1:0]  a, b, sum;
    logic          cin, cout;
    logic [SW-1:0] sa, sb, ssum;
    logic          scin, scout;

    int checks = 0;
    int errors = 0;
    int wd_cnt = 0;

    csk_adder #(.WIDTH(W), .GRP(G)) u_csk_adder (
        .a_i(a), .b_i(b), .cin_i(cin), .sum_o(sum), .cout_o(cout)
    );

    csk_adder #(.WIDTH(SW), .GRP(SG)) u_csk_adder_small (
        .a_i(sa), .b_i(sb), .cin_i(scin), .sum_o(ssum), .cout_o(scout)
    );

    task automatic check(input string tag, input logic [W:0] act, input logic [W:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive after a rising edge, sample at the following falling edge
    task automatic apply(input logic [W-1:0] av, input logic [W-1:0] bv, input logic cv);
        @(posedge clk);
        a = av; b = bv; cin = cv;
        @(negedge clk);
    endtask

    task automatic t_zero();
        apply('0, '0, 1'b0);
        check("R3 sum", {1'b0, sum}, '0);
        check("R3 cout", {{W{1'b0}}, cout}, '0);
        apply('0, '0, 1'b1);
        check("R3 sum cin", {1'b0, sum}, 33'd1);
    endtask

    task automatic t_all_prop();
        apply(32'h5A5A_5A5A, ~32'h5A5A_5A5A, 1'b0);
        check("R4 sum cin0", {cout, sum}, {1'b0, 32'hFFFF_FFFF});
        apply(32'h5A5A_5A5A, ~32'h5A5A_5A5A, 1'b1);
        check("R4 sum cin1", {cout, sum}, {1'b1, 32'h0});
    endtask

    task automatic t_skip_group();
        // group 0 generates out of bit 3, group 1 propagates it onward
        apply(32'h0000_00F8, 32'h0000_0008, 1'b0);
        check("R5 skip", {cout, sum}, {1'b0, 32'h0000_0100});
        apply(32'hF000_0000, 32'h0000_0000, 1'b0);
        check("R5 top prop", {cout, sum}, {1'b0, 32'hF000_0000});
    endtask

    task automatic t_ripple_group();
        apply(32'h0000_0080, 32'h0000_0080, 1'b1);
        check("R6 absorb", {cout, sum}, {1'b0, 32'h0000_0101});
        apply(32'h0000_0070, 32'h0000_0050, 1'b0);
        check("R6 mixed", {cout, sum}, {1'b0, 32'h0000_00C0});
    endtask

    task automatic t_worst();
        apply(32'h0000_0001, 32'hFFFF_FFFF, 1'b0);
        check("R7 worst", {cout, sum}, {1'b1, 32'h0});
        apply(32'hFFFF_FFFF, 32'h0000_0000, 1'b1);
        check("R7 cin path", {cout, sum}, {1'b1, 32'h0});
    endtask

    task automatic t_random();
        logic [W:0] exp;
        for (int n = 0; n < 3000; n++) begin
            logic [W-1:0] ra, rb;
            logic         rc;
            ra = $urandom; rb = $urandom; rc = 1'($urandom);
            if (n % 4 == 1) rb = ~ra;
            apply(ra, rb, rc);
            exp = {1'b0, ra} + {1'b0, rb} + {{W{1'b0}}, rc};
            check("R1 R2 random", {cout, sum}, exp);
        end
    endtask

    task automatic t_exhaustive();
        logic [SW:0] exp;
        for (int n = 0; n < (1 << (2*SW+1)); n++) begin
            @(posedge clk);
            sa = n[SW-1:0]; sb = n[2*SW-1:SW]; scin = n[2*SW];
            @(negedge clk);
            exp = {1'b0, sa} + {1'b0, sb} + {{SW{1'b0}}, scin};
            check("R1 R2 exhaustive", {{(W-SW){1'b0}}, scout, ssum}, {{(W-SW){1'b0}}, exp});
        end
    endtask

    always @(posedge clk) begin
        if (rst_n) begin
            wd_cnt <= wd_cnt + 1;
            if (wd_cnt == 60000) begin
                errors++;
                $display("FAIL watchdog actual=%0d expected=<60000", wd_cnt);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        a = '0; b = '0; cin = 1'b0;
        sa = '0; sb = '0; scin = 1'b0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_zero();
        t_all_prop();
        t_skip_group();
        t_ripple_group();
        t_worst();
        t_random();
        t_exhaustive();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule